// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array

This block is a behavioural model of a one-bit-wide dynamic memory whose cells form a square array of rows and columns. The row and the column address share one set of address pins. A row strobe marks when the row half of the address is on the pins. A column strobe then marks the column half. Both halves are latched, so the pins may change while the strobes are held. Every row opening is destructive. The whole row is copied into a row-wide buffer and cleared in the array, and the buffer is written back when the row strobe is released. Column reads and writes inside an open row act on that buffer, so one row opening can serve several column accesses.

A refresh scheduler raises a request once every `REFRESH_INTERVAL` clock cycles. It services the requests one row at a time, in ascending row order, and only while the row strobe is idle. Each refresh is a destructive read followed by a write-back. The model also tracks how long ago each row was last written back. A row that has gone more than `RETENTION` cycles without a write-back reads as all zeros, so the refresh path can be checked from the pins. With the default `ADDR_W` of 10 the array is 1024 by 1024.

Top module: `dram_mux_array`

## Requirements
- R1: On the clock edge where `ras_n_i` is first sampled low after being high, the value on `addr_i` is taken as the row address. Changes on `addr_i` while `ras_n_i` stays low do not change the selected row.
- R2: While a row is open, the edge where `cas_n_i` is first sampled low takes `addr_i` as the column. With `we_n_i` high this is a read: `dq_vld_o` goes to 1 and `dq_o` carries the cell value one clock after that edge. Both hold steady while `cas_n_i` stays low. `dq_vld_o` returns to 0, with `dq_o` at 0, one clock after `cas_n_i` is sampled high.
- R3: A column access with `we_n_i` low stores `din_i` into the selected cell. A later read returns that value, and `dq_vld_o` stays 0 during the write.
- R4: Asserting `cas_n_i` low while `ras_n_i` is high performs no access. `dq_vld_o` stays 0 and no cell changes.
- R5: Several column accesses, reads and writes mixed, may follow one another within a single row opening. Each one acts on the latched row.
- R6: Reading a cell does not change it. The row is cleared at opening and restored when `ras_n_i` rises, so repeated reads return the same value.
- R7: A refresh request is raised every `REFRESH_INTERVAL` cycles. A refresh starts only from idle while `ras_n_i` is high, and the refreshed row index advances by one, wrapping, after each refresh. A row kept by refresh holds its data indefinitely.
- R8: A row whose last write-back is more than `RETENTION` cycles old when it is next opened or refreshed reads as all zeros.
- R9: After a synchronous active-low reset, `dq_vld_o` and `dq_o` are 0 and every cell reads 0.
- R10: If `cas_n_i` is already low when a row opens, no access takes place until `cas_n_i` rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Low selects a write for the column access |
| addr_i | input | ADDR_W | Shared row/column address pins |
| din_i | input | 1 | Write data |
| dq_o | output | 1 | Read data, 0 when not valid |
| dq_vld_o | output | 1 | Read data valid |

## Verification
A row opens on the edge that samples `ras_n_i` low. If a refresh is already under way, the opening is deferred by up to two edges. For that reason the bench always places the column strobe three cycles after the row strobe. Read data is due one clock after the edge that samples `cas_n_i` low, and it is checked again one cycle later for stability. The clearing of the valid flag is checked one clock after `cas_n_i` rises. A behavioural reference model advances at every rising edge. Its expected `dq_o` and `dq_vld_o` are compared with the outputs at every falling edge. This covers the refresh starvation during a long row hold and the decay that follows from it.

// File: rtl/dram_mux_pkg.sv
// Shared types for the multiplexed-address dynamic memory model.
package dram_mux_pkg;

    // Controller phases: idle, row held open, refresh read, refresh write-back.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_REF_RD = 2'd2,
        ST_REF_WB = 2'd3
    } ctl_state_e;

    // Row operations the controller issues to the cell array.
    typedef enum logic [1:0] {
        ARR_NOP     = 2'd0,
        ARR_DESTROY = 2'd1,
        ARR_RESTORE = 2'd2
    } arr_op_e;

endpackage

// File: rtl/dram_strobe_latch.sv
// Address latch for one strobe.
// Captures the pins on the edge where the active-low strobe is first sampled low.
// While the capture is happening, addr_o forwards the pins directly, so the
// consumer sees the new address in that same cycle.
// Assumes the strobe is synchronous to clk.
module dram_strobe_latch #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_n_i,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] addr_o
);

    logic         prev_q;
    logic [W-1:0] lat_q;
    logic         fall;

    assign fall   = prev_q & ~strobe_n_i;
    assign addr_o = fall ? pins_i : lat_q;

    // Track the previous strobe level and hold the captured address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            lat_q  <= '0;
        end else begin
            prev_q <= strobe_n_i;
            if (fall) begin
                lat_q <= pins_i;
            end
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
// Refresh scheduler.
// Raises a single pending request every INTERVAL cycles.
// A request raised while one is already pending merges with it.
// Each done_i pulse clears the request and advances the row index, which wraps.
// Assumes INTERVAL >= 2.
module dram_refresh_sched #(
    parameter int unsigned ROW_W    = 10,
    parameter int unsigned INTERVAL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);

    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [ROW_W-1:0] row_q;
    logic             tick;

    assign tick   = (cnt_q == CNT_LAST);
    assign pend_o = pend_q;
    assign row_o  = row_q;

    // Interval timer, pending flag (a new tick wins over done) and row sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            row_q  <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (tick) begin
                pend_q <= 1'b1;
            end else if (done_i) begin
                pend_q <= 1'b0;
            end
            if (done_i) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_cell_array.sv
// Cell array with retention tracking.
// Holds ROWS x COLS bits and serves one combinational row read per cycle.
// Each cycle it applies one row operation:
//   ARR_DESTROY clears the row (the destructive read).
//   ARR_RESTORE writes the row back and records the time.
// A row that was never restored, or was restored more than RETENTION cycles
// before it is read, returns all zeros. Decay is evaluated lazily at read time,
// against a free-running cycle counter.
module dram_cell_array
    import dram_mux_pkg::*;
#(
    parameter int unsigned ROWS      = 1024,
    parameter int unsigned COLS      = 1024,
    parameter int unsigned RETENTION = 100000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(ROWS)-1:0] rd_row_i,
    output logic [COLS-1:0]         rd_data_o,
    input  arr_op_e                 op_i,
    input  logic [$clog2(ROWS)-1:0] op_row_i,
    input  logic [COLS-1:0]         wr_data_i
);

    localparam int unsigned STAMP_W = 32;
    localparam logic [STAMP_W-1:0] RET_LIM = STAMP_W'(RETENTION);

    logic [COLS-1:0]    mem_q   [ROWS];
    logic [STAMP_W-1:0] stamp_q [ROWS];
    logic [ROWS-1:0]    valid_q;
    logic [STAMP_W-1:0] now_q;
    logic [STAMP_W-1:0] age;
    logic               stale;

    assign age       = now_q - stamp_q[rd_row_i];
    assign stale     = ~valid_q[rd_row_i] | (age > RET_LIM);
    assign rd_data_o = stale ? '0 : mem_q[rd_row_i];

    // Cell contents and restore times: no reset, gated by valid_q.
    always_ff @(posedge clk) begin
        if (op_i == ARR_DESTROY) begin
            mem_q[op_row_i] <= '0;
        end else if (op_i == ARR_RESTORE) begin
            mem_q[op_row_i]   <= wr_data_i;
            stamp_q[op_row_i] <= now_q;
        end
    end

    // Cycle counter and per-row written-back flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q   <= '0;
            valid_q <= '0;
        end else begin
            now_q <= now_q + 1'b1;
            if (op_i == ARR_RESTORE) begin
                valid_q[op_row_i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_mux_array.sv
// Multiplexed-address dynamic memory, one bit wide.
// Row and column addresses arrive on the shared pins, under active-low strobes.
// Opening a row loads it into a row buffer and clears it in the array.
// Column reads and writes act on the buffer.
// Releasing the row strobe writes the buffer back to the array.
// Refresh runs only from idle with the row strobe high, and takes two cycles
// (destroy, then restore).
// A row opening that arrives during a refresh waits for it; the row address
// stays held in the latch meanwhile.
module dram_mux_array
    import dram_mux_pkg::*;
#(
    parameter int unsigned ADDR_W           = 10,
    parameter int unsigned REFRESH_INTERVAL = 64,
    parameter int unsigned RETENTION        = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              din_i,
    output logic              dq_o,
    output logic              dq_vld_o
);

    localparam int unsigned ROWS = 1 << ADDR_W;
    localparam int unsigned COLS = 1 << ADDR_W;

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] open_row_q;
    logic [COLS-1:0]   row_buf_q;
    logic              cas_done_q;
    logic              dq_q;
    logic              vld_q;

    logic [ADDR_W-1:0] ras_row;
    logic [ADDR_W-1:0] cas_col;
    logic              ref_pend;
    logic [ADDR_W-1:0] ref_row;
    logic              ref_done;

    logic [ADDR_W-1:0] arr_rd_row;
    logic [COLS-1:0]   arr_rd_data;
    arr_op_e           arr_op;
    logic [ADDR_W-1:0] arr_op_row;

    dram_strobe_latch #(.W(ADDR_W)) u_row_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (ras_n_i),
        .pins_i     (addr_i),
        .addr_o     (ras_row)
    );

    dram_strobe_latch #(.W(ADDR_W)) u_col_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (cas_n_i),
        .pins_i     (addr_i),
        .addr_o     (cas_col)
    );

    dram_refresh_sched #(
        .ROW_W    (ADDR_W),
        .INTERVAL (REFRESH_INTERVAL)
    ) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (ref_done),
        .pend_o (ref_pend),
        .row_o  (ref_row)
    );

    dram_cell_array #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .RETENTION (RETENTION)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_row_i  (arr_rd_row),
        .rd_data_o (arr_rd_data),
        .op_i      (arr_op),
        .op_row_i  (arr_op_row),
        .wr_data_i (row_buf_q)
    );

    assign ref_done = (state_q == ST_REF_WB);
    assign dq_o     = dq_q;
    assign dq_vld_o = vld_q;

    // Pick the row read and the row operation for the current phase.
    always_comb begin
        arr_rd_row = ref_row;
        arr_op     = ARR_NOP;
        arr_op_row = ref_row;
        unique case (state_q)
            ST_IDLE: begin
                arr_rd_row = ras_row;
                if (!ras_n_i) begin
                    arr_op     = ARR_DESTROY;
                    arr_op_row = ras_row;
                end
            end
            ST_OPEN: begin
                if (ras_n_i) begin
                    arr_op     = ARR_RESTORE;
                    arr_op_row = open_row_q;
                end
            end
            ST_REF_RD: arr_op = ARR_DESTROY;
            ST_REF_WB: arr_op = ARR_RESTORE;
            default: arr_op = ARR_NOP;
        endcase
    end

    // Controller sequence, row buffer and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            open_row_q <= '0;
            row_buf_q  <= '0;
            cas_done_q <= 1'b0;
            dq_q       <= 1'b0;
            vld_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!ras_n_i) begin
                        row_buf_q  <= arr_rd_data;
                        open_row_q <= ras_row;
                        cas_done_q <= ~cas_n_i;
                        state_q    <= ST_OPEN;
                    end else if (ref_pend) begin
                        state_q <= ST_REF_RD;
                    end
                end
                ST_OPEN: begin
                    if (ras_n_i) begin
                        state_q    <= ST_IDLE;
                        cas_done_q <= 1'b0;
                        vld_q      <= 1'b0;
                        dq_q       <= 1'b0;
                    end else if (cas_n_i) begin
                        cas_done_q <= 1'b0;
                        vld_q      <= 1'b0;
                        dq_q       <= 1'b0;
                    end else if (!cas_done_q) begin
                        cas_done_q <= 1'b1;
                        if (!we_n_i) begin
                            row_buf_q[cas_col] <= din_i;
                        end else begin
                            dq_q  <= row_buf_q[cas_col];
                            vld_q <= 1'b1;
                        end
                    end
                end
                ST_REF_RD: begin
                    row_buf_q <= arr_rd_data;
                    state_q   <= ST_REF_WB;
                end
                ST_REF_WB: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dram_mux_array_chk.sv
// Protocol checker for dram_mux_array.
// It is attached to the top module by the bind below and observes the strobes,
// the read outputs and the refresh sequencing.
module dram_mux_array_chk
    import dram_mux_pkg::*;
#(
    parameter int unsigned RW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          dq,
    input logic          dq_vld,
    input ctl_state_e    state,
    input logic [RW-1:0] ref_row,
    input logic          ref_done
);

    // R2: valid data follows a column strobe sampled low.
    p_vld_after_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_vld |-> $past(!cas_n));

    // R2: releasing the column strobe drops valid on the next clock.
    p_cas_high_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |=> !dq_vld);

    // R2: data holds while it stays valid.
    p_dq_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_vld && $past(dq_vld)) |-> $stable(dq));

    // R4: no read result without the row strobe.
    p_no_access_without_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_vld |-> $past(!ras_n));

    // R7: refresh begins only from idle with the row strobe high.
    p_refresh_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF_RD) |-> ($past(state) == ST_IDLE && $past(ras_n)));

    // R7: the refresh row index moves only after a completed refresh.
    p_refrow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_done |=> $stable(ref_row));

endmodule

bind dram_mux_array dram_mux_array_chk #(.RW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n_i),
    .cas_n    (cas_n_i),
    .dq       (dq_o),
    .dq_vld   (dq_vld_o),
    .state    (state_q),
    .ref_row  (ref_row),
    .ref_done (ref_done)
);

// File: tb/dram_mux_array_tb_top.sv
// Bench for dram_mux_array.
// A behavioural model advances at each rising edge and is compared at every
// falling edge. Directed checks name the requirement they cover.
module dram_mux_array_tb_top;

    localparam int AW  = 4;
    localparam int N   = 16;
    localparam int INT = 10;
    localparam int RET = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic          din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dq;
    logic          dq_vld;

    always #5 clk = ~clk;

    dram_mux_array #(
        .ADDR_W           (AW),
        .REFRESH_INTERVAL (INT),
        .RETENTION        (RET)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n_i  (ras_n),
        .cas_n_i  (cas_n),
        .we_n_i   (we_n),
        .addr_i   (addr),
        .din_i    (din),
        .dq_o     (dq),
        .dq_vld_o (dq_vld)
    );

    int    checks = 0;
    int    fails = 0;
    bit    finished = 1'b0;
    bit    model_on = 1'b0;
    string cur_req = "R9";

    // Reference model state.
    bit [N-1:0] mm [N];
    bit [N-1:0] mbuf;
    bit         mvalid [N];
    int         mstamp [N];
    int         mnow, mstate, mrasprev, mcasprev, mrowlat, mcollat;
    int         mcnt, mref, mopen;
    bit         mpend, mcasdone, edq, evld;

    function automatic bit m_stale(int r);
        return !mvalid[r] || ((mnow - mstamp[r]) > RET);
    endfunction

    // Behavioural model of the requirements, advanced at each rising edge.
    always @(posedge clk) begin : model
        int  rr, cc;
        bit  tick, dn;
        if (!rst_n) begin
            mstate = 0; mrasprev = 1; mcasprev = 1; mrowlat = 0; mcollat = 0;
            mcnt = 0; mpend = 0; mref = 0; mopen = 0; mnow = 0;
            mcasdone = 0; edq = 0; evld = 0; mbuf = '0;
            for (int i = 0; i < N; i++) mvalid[i] = 0;
        end else begin
            rr = (mrasprev == 1 && !ras_n) ? int'(addr) : mrowlat;
            cc = (mcasprev == 1 && !cas_n) ? int'(addr) : mcollat;
            dn = 0;
            case (mstate)
                0: begin
                    if (!ras_n) begin
                        mbuf = m_stale(rr) ? '0 : mm[rr];
                        mm[rr] = '0;
                        mopen = rr; mcasdone = !cas_n; mstate = 1;
                    end else if (mpend) begin
                        mstate = 2;
                    end
                end
                1: begin
                    if (ras_n) begin
                        mm[mopen] = mbuf; mvalid[mopen] = 1; mstamp[mopen] = mnow;
                        mstate = 0; evld = 0; edq = 0; mcasdone = 0;
                    end else if (cas_n) begin
                        mcasdone = 0; evld = 0; edq = 0;
                    end else if (!mcasdone) begin
                        mcasdone = 1;
                        if (!we_n) mbuf[cc] = din;
                        else begin edq = mbuf[cc]; evld = 1; end
                    end
                end
                2: begin
                    mbuf = m_stale(mref) ? '0 : mm[mref];
                    mm[mref] = '0;
                    mstate = 3;
                end
                default: begin
                    mm[mref] = mbuf; mvalid[mref] = 1; mstamp[mref] = mnow;
                    dn = 1; mstate = 0;
                end
            endcase
            tick = (mcnt == INT - 1);
            mcnt = tick ? 0 : mcnt + 1;
            if (tick) mpend = 1;
            else if (dn) mpend = 0;
            if (dn) mref = (mref + 1) % N;
            if (mrasprev == 1 && !ras_n) mrowlat = int'(addr);
            if (mcasprev == 1 && !cas_n) mcollat = int'(addr);
            mrasprev = ras_n ? 1 : 0;
            mcasprev = cas_n ? 1 : 0;
            mnow = mnow + 1;
        end
    end

    // Compare the outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (dq !== edq || dq_vld !== evld) begin
                fails++;
                $display("FAIL %s model dq/vld actual=%0d/%0d expected=%0d/%0d",
                         cur_req, dq, dq_vld, edq, evld);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic open_row(input int row);
        @(negedge clk);
        addr = AW'(row); ras_n = 1'b0;
        @(negedge clk);
        addr = ~AW'(row);
        @(negedge clk);
    endtask

    task automatic close_row();
        @(negedge clk);
        ras_n = 1'b1; addr = '0;
        @(negedge clk);
    endtask

    task automatic cas_op(input int col, input bit wr, input bit d, output bit got);
        @(negedge clk);
        addr = AW'(col); cas_n = 1'b0; we_n = !wr; din = d;
        @(negedge clk);
        addr = '0;
        check("R2 valid after CAS", dq_vld, wr ? 0 : 1);
        got = dq;
        @(negedge clk);
        check("R2 data held", dq, wr ? 0 : int'(got));
        check("R2 valid held", dq_vld, wr ? 0 : 1);
        cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        check("R2 valid drops", dq_vld, 0);
    endtask

    task automatic wr_cell(input int row, input int col, input bit d);
        bit g;
        open_row(row);
        cas_op(col, 1'b1, d, g);
        close_row();
    endtask

    task automatic rd_cell(input string tag, input int row, input int col, input bit exp);
        bit g;
        open_row(row);
        cas_op(col, 1'b0, 1'b0, g);
        close_row();
        check(tag, g, exp);
    endtask

    initial begin
        bit g;
        repeat (4) @(negedge clk);
        check("R9 reset valid", dq_vld, 0);
        check("R9 reset data", dq, 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        cur_req = "R9";
        rd_cell("R9 cell zero after reset", 3, 3, 1'b0);

        cur_req = "R3";
        wr_cell(2, 5, 1'b1);
        wr_cell(2, 6, 1'b0);
        wr_cell(7, 0, 1'b1);
        rd_cell("R3 write one", 2, 5, 1'b1);
        rd_cell("R3 write zero", 2, 6, 1'b0);
        rd_cell("R1 row latched, other row", 7, 0, 1'b1);

        cur_req = "R6";
        rd_cell("R6 reread intact", 2, 5, 1'b1);
        rd_cell("R6 third read", 2, 5, 1'b1);

        cur_req = "R5";
        open_row(4);
        cas_op(1, 1'b1, 1'b1, g);
        cas_op(3, 1'b1, 1'b1, g);
        cas_op(1, 1'b0, 1'b0, g); check("R5 page col1", g, 1);
        cas_op(2, 1'b0, 1'b0, g); check("R5 page col2", g, 0);
        cas_op(3, 1'b0, 1'b0, g); check("R5 page col3", g, 1);
        close_row();
        rd_cell("R5 page written back", 4, 3, 1'b1);

        cur_req = "R4";
        @(negedge clk);
        addr = 4'd6; cas_n = 1'b0; we_n = 1'b0; din = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R4 no access without RAS", dq_vld, 0);
        end
        cas_n = 1'b1; we_n = 1'b1; din = 1'b0;
        @(negedge clk);
        rd_cell("R4 cell untouched", 2, 6, 1'b0);

        cur_req = "R10";
        @(negedge clk);
        addr = 4'd9; cas_n = 1'b0;
        @(negedge clk);
        addr = 4'd4; ras_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 early CAS ignored", dq_vld, 0);
        end
        cas_n = 1'b1;
        @(negedge clk);
        cas_op(1, 1'b0, 1'b0, g);
        check("R10 access after new CAS", g, 1);
        close_row();

        cur_req = "R7";
        repeat (500) @(negedge clk);
        rd_cell("R7 refreshed row kept", 2, 5, 1'b1);
        rd_cell("R7 refreshed row kept b", 4, 3, 1'b1);
        rd_cell("R7 refreshed row kept c", 7, 0, 1'b1);

        cur_req = "R8";
        open_row(7);
        repeat (600) @(negedge clk);
        close_row();
        rd_cell("R8 starved row decayed", 2, 5, 1'b0);
        rd_cell("R8 starved row decayed b", 4, 1, 1'b0);
        rd_cell("R8 held row restored", 7, 0, 1'b1);

        cur_req = "R3";
        wr_cell(2, 5, 1'b1);
        rd_cell("R3 rewrite after decay", 2, 5, 1'b1);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule